// File: doc/BRIEF.md
# Two-Entry Register File with Port-Equality Flag

This block stores two 16-bit working registers, called register zero and register one, for a small datapath. Two read ports present register contents to downstream logic, and a single write port loads a 16-bit input word into either register, into both at once, or into neither. Each read port picks its source with its own bit of a 2-bit read-select code. A flag reports whether the two read ports currently carry the same value. Both stored values are also brought out on dedicated debug outputs.

All storage changes on the rising edge of the one clock. Reset is synchronous and clears both registers. The read ports, the flag and the debug outputs are combinational functions of the stored contents and the read-select code. A write therefore appears on the outputs only after the clock edge that performs it; there is no forwarding from the write input to the read ports.

Top module: `dual_reg_file`

## Requirements
- R1: While `rst` is high at a rising clock edge, both registers become zero, so every data output and debug output reads zero after that edge.
- R2: Reset wins over a write in the same cycle: with `rst` high, any `wrSel` value leaves both registers zero.
- R3: `wrSel` = 2'b00 writes nothing; both registers keep their values across the edge.
- R4: `wrSel` = 2'b01 loads `wrData` into register zero at the edge and leaves register one unchanged (bit 0 of `wrSel` enables register zero).
- R5: `wrSel` = 2'b10 loads `wrData` into register one at the edge and leaves register zero unchanged (bit 1 of `wrSel` enables register one).
- R6: `wrSel` = 2'b11 loads the same `wrData` into both registers at the same edge.
- R7: Bit 0 of `rdSel` chooses the source of `rdPort0`: 0 selects register zero, 1 selects register one.
- R8: Bit 1 of `rdSel` chooses the source of `rdPort1`: 0 selects register zero, 1 selects register one.
- R9: `portsEqual` is 1 exactly when `rdPort0` and `rdPort1` carry identical values; with `rdSel` = 2'b00 or 2'b11 it is always 1.
- R10: `regZeroView` and `regOneView` always show the current contents of register zero and register one.
- R11: A write is not visible on any output before the clock edge that performs it; between the edges the outputs reflect the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all storage |
| rst | input | 1 | Synchronous reset, active high |
| wrData | input | 16 | Word to be written |
| wrSel | input | 2 | Write enable code: bit 0 register zero, bit 1 register one |
| rdSel | input | 2 | Read select: bit 0 for `rdPort0`, bit 1 for `rdPort1` |
| rdPort0 | output | 16 | First read port |
| rdPort1 | output | 16 | Second read port |
| portsEqual | output | 1 | High when both read ports carry identical values |
| regZeroView | output | 16 | Debug copy of register zero |
| regOneView | output | 16 | Debug copy of register one |

## Verification
The hardest case to reach from the ports is one where the equality flag goes high through data and not through the select code. The two registers have to hold equal values by separate routes while the read ports point at different registers. The stimulus gets there in two ways: it loads both registers with the dual-write code, and it writes register zero and register one one at a time with the same word. It then crosses the ports with `rdSel` = 2'b01 and 2'b10. It also drives a write with reset held high and samples the outputs between the driving edge and the next one, to show that reset takes priority and that nothing is forwarded.

// File: rtl/dual_reg_file_pkg.sv
package dual_reg_file_pkg;
  localparam int DATA_W    = 16;
  localparam int REG_COUNT = 2;
  localparam int SEL_W     = $clog2(REG_COUNT);

  // Strobes from the control decoder to the storage datapath
  typedef struct packed {
    logic                 clearAll;
    logic [REG_COUNT-1:0] load;
    logic [SEL_W-1:0]     srcPort0;
    logic [SEL_W-1:0]     srcPort1;
  } rfStrobes_t;
endpackage

// File: rtl/dual_reg_file_ctrl.sv
module dual_reg_file_ctrl
  import dual_reg_file_pkg::*;
#(
  parameter int NREG = REG_COUNT
) (
  input  logic            rst,
  input  logic [NREG-1:0] wrSel,
  input  logic [NREG-1:0] rdSel,
  output rfStrobes_t      strobes
);
  // Each write-select bit enables one register; reset masks all loads.
  always_comb begin
    strobes.clearAll = rst;
    strobes.load     = rst ? '0 : wrSel;
    strobes.srcPort0 = rdSel[0];
    strobes.srcPort1 = rdSel[NREG-1];
  end
endmodule

// File: rtl/dual_reg_file_dp.sv
module dual_reg_file_dp
  import dual_reg_file_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int NREG  = REG_COUNT
) (
  input  logic             clk,
  input  rfStrobes_t       strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdPort0,
  output logic [WIDTH-1:0] rdPort1,
  output logic             portsEqual,
  output logic [WIDTH-1:0] regView [NREG]
);
  logic [WIDTH-1:0] store [NREG];

  for (genvar i = 0; i < NREG; i++) begin : gReg
    always_ff @(posedge clk) begin
      if (strobes.clearAll)     store[i] <= '0;
      else if (strobes.load[i]) store[i] <= wrData;
    end
    assign regView[i] = store[i];
  end

  always_comb begin
    rdPort0    = store[strobes.srcPort0];
    rdPort1    = store[strobes.srcPort1];
    portsEqual = (rdPort0 == rdPort1);
  end
endmodule

// File: rtl/dual_reg_file.sv
module dual_reg_file
  import dual_reg_file_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        wrSel,
  input  logic [1:0]        rdSel,
  output logic [DATA_W-1:0] rdPort0,
  output logic [DATA_W-1:0] rdPort1,
  output logic              portsEqual,
  output logic [DATA_W-1:0] regZeroView,
  output logic [DATA_W-1:0] regOneView
);
  rfStrobes_t       strobes;
  logic [DATA_W-1:0] views [REG_COUNT];

  dual_reg_file_ctrl #(.NREG(REG_COUNT)) uCtrl (
    .rst(rst), .wrSel(wrSel), .rdSel(rdSel), .strobes(strobes)
  );

  dual_reg_file_dp #(.WIDTH(DATA_W), .NREG(REG_COUNT)) uDp (
    .clk(clk), .strobes(strobes), .wrData(wrData),
    .rdPort0(rdPort0), .rdPort1(rdPort1), .portsEqual(portsEqual),
    .regView(views)
  );

  assign regZeroView = views[0];
  assign regOneView  = views[1];
endmodule

// File: rtl/dual_reg_file_checker.sv
module dual_reg_file_checker
  import dual_reg_file_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] wrData,
  input logic [1:0]        wrSel,
  input logic [1:0]        rdSel,
  input logic [DATA_W-1:0] rdPort0,
  input logic [DATA_W-1:0] rdPort1,
  input logic              portsEqual,
  input logic [DATA_W-1:0] regZeroView,
  input logic [DATA_W-1:0] regOneView
);
  // R1 and R2: the first cycle after reset shows cleared storage
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (regZeroView == '0 && regOneView == '0));

  assert_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wrSel == 2'b00) |=> ($stable(regZeroView) && $stable(regOneView)));

  assert_write_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (wrSel == 2'b01) |=> (regZeroView == $past(wrData) && $stable(regOneView)));

  assert_write_one_R5: assert property (@(posedge clk) disable iff (rst)
    (wrSel == 2'b10) |=> (regOneView == $past(wrData) && $stable(regZeroView)));

  assert_write_both_R6: assert property (@(posedge clk) disable iff (rst)
    (wrSel == 2'b11) |=> (regZeroView == $past(wrData) && regOneView == $past(wrData)));

  assert_port0_src_R7: assert property (@(posedge clk) disable iff (rst)
    rdPort0 == (rdSel[0] ? regOneView : regZeroView));

  assert_port1_src_R8: assert property (@(posedge clk) disable iff (rst)
    rdPort1 == (rdSel[1] ? regOneView : regZeroView));

  assert_same_src_eq_R9: assert property (@(posedge clk) disable iff (rst)
    (rdSel == 2'b00 || rdSel == 2'b11) |-> portsEqual);

  assert_eq_implies_match_R9: assert property (@(posedge clk) disable iff (rst)
    portsEqual |-> (rdPort0 == rdPort1));
endmodule

bind dual_reg_file dual_reg_file_checker uChk (
  .clk(clk), .rst(rst), .wrData(wrData), .wrSel(wrSel), .rdSel(rdSel),
  .rdPort0(rdPort0), .rdPort1(rdPort1), .portsEqual(portsEqual),
  .regZeroView(regZeroView), .regOneView(regOneView)
);

// File: tb/dual_reg_file_test.sv
module dual_reg_file_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] wrData = '0;
  logic [1:0]  wrSel = '0;
  logic [1:0]  rdSel = '0;
  logic [15:0] rdPort0, rdPort1, regZeroView, regOneView;
  logic        portsEqual;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] mReg0 = '0;
  logic [15:0] mReg1 = '0;

  typedef struct {
    logic [15:0] p0;
    logic [15:0] p1;
    logic        eq;
    logic [15:0] v0;
    logic [15:0] v1;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  dual_reg_file uut (
    .clk(clk), .rst(rst), .wrData(wrData), .wrSel(wrSel), .rdSel(rdSel),
    .rdPort0(rdPort0), .rdPort1(rdPort1), .portsEqual(portsEqual),
    .regZeroView(regZeroView), .regOneView(regOneView)
  );

  task automatic compare(input expItem_t e);
    compared++;
    if (rdPort0 !== e.p0 || rdPort1 !== e.p1 || portsEqual !== e.eq ||
        regZeroView !== e.v0 || regOneView !== e.v1) begin
      mismatched++;
      $display("FAIL %s: got p0=%h p1=%h eq=%b v0=%h v1=%h expected p0=%h p1=%h eq=%b v0=%h v1=%h",
               e.tag, rdPort0, rdPort1, portsEqual, regZeroView, regOneView,
               e.p0, e.p1, e.eq, e.v0, e.v1);
    end
  endtask

  function automatic expItem_t predict(input logic [1:0] rs, input string tag);
    expItem_t e;
    e.p0 = rs[0] ? mReg1 : mReg0;
    e.p1 = rs[1] ? mReg1 : mReg0;
    e.eq = (e.p0 == e.p1);
    e.v0 = mReg0;
    e.v1 = mReg1;
    e.tag = tag;
    return e;
  endfunction

  // Driver: apply inputs, check nothing leaks before the edge (R11),
  // then push the post-edge expectation for the monitor.
  task automatic step(input logic r, input logic [1:0] ws, input logic [15:0] d,
                      input logic [1:0] rs, input string tag);
    @(negedge clk);
    rst = r; wrSel = ws; wrData = d; rdSel = rs;
    #2;
    if (!r && ws != 2'b00) compare(predict(rs, "R11 pre-edge"));
    @(posedge clk);
    if (r) begin
      mReg0 = '0; mReg1 = '0;
    end else begin
      if (ws[0]) mReg0 = d;
      if (ws[1]) mReg1 = d;
    end
    expQ.push_back(predict(rs, tag));
  endtask

  // Monitor: pops one expectation per edge, sampled away from the edge
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) compare(expQ.pop_front());
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    step(1'b1, 2'b00, 16'h0000, 2'b00, "R1 reset");
    step(1'b1, 2'b11, 16'hBEEF, 2'b01, "R2 reset over write");
    step(1'b0, 2'b01, 16'h1234, 2'b01, "R4 write zero");
    step(1'b0, 2'b10, 16'hA5A5, 2'b10, "R5 write one");
    step(1'b0, 2'b00, 16'hFFFF, 2'b01, "R3 no write");
    step(1'b0, 2'b00, 16'h0000, 2'b00, "R7 R8 R9 sel00");
    step(1'b0, 2'b00, 16'h0000, 2'b01, "R7 sel01");
    step(1'b0, 2'b00, 16'h0000, 2'b10, "R8 sel10");
    step(1'b0, 2'b00, 16'h0000, 2'b11, "R9 sel11 eq");
    step(1'b0, 2'b11, 16'h5A3C, 2'b01, "R6 write both eq");
    step(1'b0, 2'b01, 16'h0F0F, 2'b10, "R4 R10 diverge");
    step(1'b0, 2'b10, 16'h0F0F, 2'b01, "R9 equal by data");
    step(1'b0, 2'b01, 16'h0F0E, 2'b10, "R9 one-bit differ");
    step(1'b0, 2'b00, 16'h0000, 2'b11, "R9 sel11 differing regs");
    step(1'b1, 2'b01, 16'h7777, 2'b10, "R2 reset over single write");
    step(1'b0, 2'b10, 16'hFFFF, 2'b11, "R5 R10 after reset");
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 2'(k % 4), 16'(k * 16'h1357 + 3), 2'((k * 3) % 4), "R10 mixed");
    end
    step(1'b0, 2'b00, 16'h0000, 2'b00, "R3 final hold");
    @(posedge clk);
    #8;
    finishRun();
  end
endmodule